// File: doc/BRIEF.md
# Platform Interrupt Router with Claim/Complete

This block collects a parameterised number of external interrupt sources and routes them to a parameterised number of hart contexts. Every source enters through its own gateway. The gateway is set for level or edge triggering and turns the raw input into a pending request. For each context, a combinational arbiter looks at the sources that are pending, enabled for that context and above that context's threshold. It drives the context's interrupt line and offers the winning source ID.

Software uses a single register-style access port, one operation per cycle. It programs priorities, trigger types, per-context enables and thresholds. It claims the winning source by reading the claim selector, and it finishes service by writing the source ID back to the same selector. For edges that arrive during service, an instance parameter picks one of two behaviours: a saturating counter queues them for later delivery, or they are dropped. Supervisor-mode accesses are accepted only after machine mode sets a delegation bit. Context slots can be marked absent by parameter.

Each gateway is a three-state machine:
- **GW_IDLE → GW_PEND**: a level source is high, or an edge source sees a rising edge or has a queued edge.
- **GW_PEND → GW_INFL**: the source is claimed, and the claiming context is recorded as its owner.
- **GW_INFL → GW_IDLE**: the owner writes a completion that names this source.

Top module: `irq_hub`

## Requirements
- R1: After reset, every context line is low, the read data is 0, and all priorities, enables, thresholds, trigger types and the delegation bit are 0.
- R2: A pending source drives only the lines of contexts for which it is enabled. The enable is written with selector 1, where bit 0 of the write data is the enable for the pair of context and source ID.
- R3: Among the qualifying sources of a context, the one with the highest priority wins. On equal priority the lowest source ID wins. Priority uses selector 0 with data bits [PRIO_W-1:0]. Source IDs start at 1, and ID 0 means no source.
- R4: A source qualifies for a context only if its priority is strictly greater than that context's threshold (selector 2). This means priority 0 never raises a line.
- R5: A claim is a read of selector 3 for a context. It returns the winning ID one cycle later, or 0 if no source qualifies. The claimed source leaves the pending state at once and is not offered again until it is completed.
- R6: A completion is a write of selector 3 whose data is the source ID. It takes effect only if it comes from the context that claimed that source. Any other completion has no effect.
- R7: A level source (trigger bit 0) that is still high when its completion arrives becomes pending again one cycle later.
- R8: An edge source (trigger bit 1, selector 4) becomes pending on a rising input. Further edges while it is already pending are merged into that one request.
- R9: In queue mode, edges that arrive while the source is claimed are counted, up to 2^QCNT_W-1. Each completion then delivers one of them again.
- R10: In drop mode, edges that arrive while the source is claimed are discarded.
- R11: While the delegation bit (selector 5, data bit 0) is clear, supervisor accesses are ignored: writes change nothing, and reads, including claims, return 0 and claim nothing. Only machine mode can write the delegation bit.
- R12: A context marked absent, or a context index out of range, never raises its line. Its claims return 0, and enable or threshold writes for it are discarded.
- R13: Every accepted read returns the addressed value on rd_data in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Raw source inputs; bit i is source ID i+1 |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_super | input | 1 | 1 for supervisor-mode access, 0 for machine mode |
| acc_sel | input | 3 | Selector: 0 priority, 1 enable, 2 threshold, 3 claim/complete, 4 trigger, 5 delegation |
| acc_ctx | input | CTX_W | Context index |
| acc_idx | input | ID_W | Source ID |
| acc_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read result, registered |
| ctx_irq | output | NCTX | Interrupt line per context |

## Verification
The bound checker checks four things on every cycle:
- A raised line always has a pending source behind it.
- A threshold at its maximum keeps its line low.
- A claim taken while the line is low returns 0, and a claim taken while the line is high returns a nonzero ID whose source is now in service.
- An ignored supervisor write leaves the whole configuration unchanged.

The following can only be shown by the bench's scenarios, which run a queue-mode instance and a drop-mode instance side by side against a behavioural model: the ordering of claims by priority and ID, completions rejected from the wrong context, level re-arming, merging and saturation of queued edges, the difference between dropping and queueing, and absent contexts.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;
    typedef enum logic [2:0] {
        SEL_PRIO   = 3'd0,
        SEL_ENABLE = 3'd1,
        SEL_THRESH = 3'd2,
        SEL_CLAIM  = 3'd3,
        SEL_TRIG   = 3'd4,
        SEL_DELEG  = 3'd5
    } acc_sel_e;

    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_INFL = 2'd2
    } gw_state_e;
endpackage

// File: rtl/irq_gateway.sv
`timescale 1ns/1ps
module irq_gateway
    import irq_hub_pkg::*;
#(
    parameter int CTX_W      = 2,
    parameter int QCNT_W     = 2,
    parameter bit EDGE_QUEUE = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_in,
    input  logic             edge_mode,
    input  logic             claim_i,
    input  logic [CTX_W-1:0] claim_ctx_i,
    input  logic             complete_i,
    input  logic [CTX_W-1:0] cpl_ctx_i,
    output logic             pending_o,
    output logic             inflight_o
);
    gw_state_e        state_q, state_d;
    logic [CTX_W-1:0] owner_q;
    logic             src_q;
    logic             edge_now;
    logic             has_backlog;
    logic             cnt_inc, cnt_dec;

    assign edge_now = edge_mode & src_in & ~src_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GW_IDLE;
            owner_q <= '0;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src_in;
            if (state_q == GW_PEND && claim_i) begin
                owner_q <= claim_ctx_i;
            end
        end
    end

    // Next state and backlog requests
    always_comb begin
        state_d = state_q;
        cnt_inc = 1'b0;
        cnt_dec = 1'b0;
        unique case (state_q)
            GW_IDLE: begin
                if (edge_mode ? (edge_now || has_backlog) : src_in) begin
                    state_d = GW_PEND;
                    cnt_dec = edge_mode && !edge_now && has_backlog;
                end
            end
            GW_PEND: begin
                if (claim_i) begin
                    state_d = GW_INFL;
                    cnt_inc = edge_now;
                end
            end
            GW_INFL: begin
                cnt_inc = edge_now;
                if (complete_i && cpl_ctx_i == owner_q) begin
                    state_d = GW_IDLE;
                end
            end
            default: state_d = GW_IDLE;
        endcase
    end

    generate
        if (EDGE_QUEUE) begin : g_queue
            localparam logic [QCNT_W-1:0] CNT_MAX = '1;
            logic [QCNT_W-1:0] cnt_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_inc && cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + 1'b1;
                end else if (cnt_dec) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            assign has_backlog = (cnt_q != '0);
        end else begin : g_drop
            logic unused_drop;
            assign unused_drop = cnt_inc | cnt_dec;
            assign has_backlog = 1'b0;
        end
    endgenerate

    // Outputs
    always_comb begin
        pending_o  = (state_q == GW_PEND);
        inflight_o = (state_q == GW_INFL);
    end
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
    parameter int NSRC   = 7,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 3
) (
    input  logic [NSRC-1:0]        cand_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]      thr_i,
    output logic [ID_W-1:0]        win_id_o,
    output logic                   irq_o
);
    logic [PRIO_W-1:0] best_p;
    logic [PRIO_W-1:0] cur_p;

    // Strict compare seeded with the threshold: above-threshold only,
    // lowest ID kept on a tie.
    always_comb begin
        best_p   = thr_i;
        win_id_o = '0;
        cur_p    = '0;
        for (int i = 0; i < NSRC; i++) begin
            cur_p = prio_i[i*PRIO_W +: PRIO_W];
            if (cand_i[i] && cur_p > best_p) begin
                best_p   = cur_p;
                win_id_o = ID_W'(i + 1);
            end
        end
        irq_o = (win_id_o != '0);
    end
endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int             NSRC        = 7,
    parameter int             NCTX        = 3,
    parameter int             PRIO_W      = 3,
    parameter int             QCNT_W      = 2,
    parameter int             DATA_W      = 8,
    parameter bit             EDGE_QUEUE  = 1'b1,
    parameter logic [NCTX-1:0] CTX_PRESENT = 3'b101,
    localparam int            ID_W        = $clog2(NSRC + 1),
    localparam int            CTX_W       = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_in,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_super,
    input  logic [2:0]        acc_sel,
    input  logic [CTX_W-1:0]  acc_ctx,
    input  logic [ID_W-1:0]   acc_idx,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCTX-1:0]   ctx_irq
);
    logic [NSRC-1:0][PRIO_W-1:0] prio_q;
    logic [NSRC-1:0]             trig_q;
    logic [NCTX-1:0][NSRC-1:0]   en_q;
    logic [NCTX-1:0][PRIO_W-1:0] thr_q;
    logic                        deleg_q;
    logic [DATA_W-1:0]           rd_q;
    logic [DATA_W-1:0]           rd_val;

    logic [NSRC-1:0]             pend_vec;
    logic [NSRC-1:0]             inflight_vec;
    logic [NCTX-1:0][ID_W-1:0]   win_id;
    logic [ID_W-1:0]             sel_win;

    acc_sel_e sel;
    logic     acc_ok, ctx_ok, wr_ok, rd_ok, claim_rd, cpl_wr;

    assign sel      = acc_sel_e'(acc_sel);
    assign acc_ok   = acc_valid && (!acc_super || deleg_q);
    assign wr_ok    = acc_ok && acc_write;
    assign rd_ok    = acc_ok && !acc_write;
    assign claim_rd = rd_ok && sel == SEL_CLAIM && ctx_ok;
    assign cpl_wr   = wr_ok && sel == SEL_CLAIM && ctx_ok;

    always_comb begin
        ctx_ok  = 1'b0;
        sel_win = '0;
        for (int c = 0; c < NCTX; c++) begin
            if (acc_ctx == CTX_W'(c) && CTX_PRESENT[c]) begin
                ctx_ok  = 1'b1;
                sel_win = win_id[c];
            end
        end
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q  <= '0;
            trig_q  <= '0;
            en_q    <= '0;
            thr_q   <= '0;
            deleg_q <= 1'b0;
        end else if (wr_ok) begin
            case (sel)
                SEL_PRIO: begin
                    for (int i = 0; i < NSRC; i++) begin
                        if (acc_idx == ID_W'(i + 1)) prio_q[i] <= acc_wdata[PRIO_W-1:0];
                    end
                end
                SEL_ENABLE: begin
                    for (int c = 0; c < NCTX; c++) begin
                        for (int i = 0; i < NSRC; i++) begin
                            if (CTX_PRESENT[c] && acc_ctx == CTX_W'(c) && acc_idx == ID_W'(i + 1)) begin
                                en_q[c][i] <= acc_wdata[0];
                            end
                        end
                    end
                end
                SEL_THRESH: begin
                    for (int c = 0; c < NCTX; c++) begin
                        if (CTX_PRESENT[c] && acc_ctx == CTX_W'(c)) thr_q[c] <= acc_wdata[PRIO_W-1:0];
                    end
                end
                SEL_TRIG: begin
                    for (int i = 0; i < NSRC; i++) begin
                        if (acc_idx == ID_W'(i + 1)) trig_q[i] <= acc_wdata[0];
                    end
                end
                SEL_DELEG: begin
                    if (!acc_super) deleg_q <= acc_wdata[0];
                end
                default: ;
            endcase
        end
    end

    // Read mux
    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_PRIO: begin
                for (int i = 0; i < NSRC; i++) begin
                    if (acc_idx == ID_W'(i + 1)) rd_val = DATA_W'(prio_q[i]);
                end
            end
            SEL_ENABLE: begin
                for (int c = 0; c < NCTX; c++) begin
                    for (int i = 0; i < NSRC; i++) begin
                        if (acc_ctx == CTX_W'(c) && acc_idx == ID_W'(i + 1)) rd_val = DATA_W'(en_q[c][i]);
                    end
                end
            end
            SEL_THRESH: begin
                for (int c = 0; c < NCTX; c++) begin
                    if (acc_ctx == CTX_W'(c)) rd_val = DATA_W'(thr_q[c]);
                end
            end
            SEL_CLAIM: rd_val = DATA_W'(sel_win);
            SEL_TRIG: begin
                for (int i = 0; i < NSRC; i++) begin
                    if (acc_idx == ID_W'(i + 1)) rd_val = DATA_W'(trig_q[i]);
                end
            end
            SEL_DELEG: rd_val = DATA_W'(deleg_q);
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (acc_valid && !acc_write) begin
            rd_q <= acc_ok ? rd_val : '0;
        end
    end
    assign rd_data = rd_q;

    // One gateway per source
    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            irq_gateway #(
                .CTX_W      (CTX_W),
                .QCNT_W     (QCNT_W),
                .EDGE_QUEUE (EDGE_QUEUE)
            ) gw_i (
                .clk         (clk),
                .rst_n       (rst_n),
                .src_in      (src_in[i]),
                .edge_mode   (trig_q[i]),
                .claim_i     (claim_rd && sel_win == ID_W'(i + 1)),
                .claim_ctx_i (acc_ctx),
                .complete_i  (cpl_wr && acc_wdata == DATA_W'(i + 1)),
                .cpl_ctx_i   (acc_ctx),
                .pending_o   (pend_vec[i]),
                .inflight_o  (inflight_vec[i])
            );
        end
    endgenerate

    // One arbiter per present context
    generate
        for (genvar c = 0; c < NCTX; c++) begin : g_ctx
            if (CTX_PRESENT[c]) begin : g_on
                irq_arbiter #(
                    .NSRC   (NSRC),
                    .PRIO_W (PRIO_W),
                    .ID_W   (ID_W)
                ) arb_i (
                    .cand_i   (pend_vec & en_q[c]),
                    .prio_i   (prio_q),
                    .thr_i    (thr_q[c]),
                    .win_id_o (win_id[c]),
                    .irq_o    (ctx_irq[c])
                );
            end else begin : g_off
                assign win_id[c]  = '0;
                assign ctx_irq[c] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_hub_chk.sv
`timescale 1ns/1ps
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int NSRC   = 7,
    parameter int NCTX   = 3,
    parameter int PRIO_W = 3,
    parameter int DATA_W = 8,
    parameter int ID_W   = 3,
    parameter int CTX_W  = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        acc_valid,
    input logic                        acc_write,
    input logic                        acc_super,
    input logic [2:0]                  acc_sel,
    input logic [CTX_W-1:0]            acc_ctx,
    input logic [DATA_W-1:0]           rd_data,
    input logic [NCTX-1:0]             ctx_irq,
    input logic                        deleg_q,
    input logic [NSRC-1:0][PRIO_W-1:0] prio_q,
    input logic [NSRC-1:0]             trig_q,
    input logic [NCTX-1:0][NSRC-1:0]   en_q,
    input logic [NCTX-1:0][PRIO_W-1:0] thr_q,
    input logic [NSRC-1:0]             pend_vec,
    input logic [NSRC-1:0]             inflight_vec
);
    logic line_sel;
    logic rd_hit;
    logic claim_take;

    always_comb begin
        line_sel = 1'b0;
        for (int c = 0; c < NCTX; c++) begin
            if (acc_ctx == CTX_W'(c)) line_sel = ctx_irq[c];
        end
        rd_hit = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (rd_data == DATA_W'(i + 1)) rd_hit = inflight_vec[i];
        end
    end

    assign claim_take = acc_valid && !acc_write && (!acc_super || deleg_q)
                        && acc_sel == SEL_CLAIM;

    assert_line_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_irq != '0) |-> (pend_vec != '0));

    assert_claim_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_take && !line_sel) |=> (rd_data == '0));

    assert_claim_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_take && line_sel) |=> (rd_data != '0 && rd_hit));

    assert_deleg_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_super && !deleg_q)
        |=> $stable({prio_q, trig_q, en_q, thr_q, deleg_q}));

    generate
        for (genvar c = 0; c < NCTX; c++) begin : g_thr
            assert_max_thr_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (thr_q[c] == '1) |-> !ctx_irq[c]);
        end
    endgenerate
endmodule

bind irq_hub irq_hub_chk #(
    .NSRC   (NSRC),
    .NCTX   (NCTX),
    .PRIO_W (PRIO_W),
    .DATA_W (DATA_W),
    .ID_W   (ID_W),
    .CTX_W  (CTX_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_super    (acc_super),
    .acc_sel      (acc_sel),
    .acc_ctx      (acc_ctx),
    .rd_data      (rd_data),
    .ctx_irq      (ctx_irq),
    .deleg_q      (deleg_q),
    .prio_q       (prio_q),
    .trig_q       (trig_q),
    .en_q         (en_q),
    .thr_q        (thr_q),
    .pend_vec     (pend_vec),
    .inflight_vec (inflight_vec)
);

// File: tb/irq_hub_tb_top.sv
`timescale 1ns/1ps
module irq_hub_tb_top;
    localparam int NS = 7;
    localparam int NC = 3;
    localparam logic [2:0] PRES = 3'b101;
    localparam int CMAX = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src = '0;
    logic       acc_valid = 1'b0, acc_write = 1'b0, acc_super = 1'b0;
    logic [2:0] acc_sel = '0;
    logic [1:0] acc_ctx = '0;
    logic [2:0] acc_idx = '0;
    logic [7:0] acc_wdata = '0;
    logic [7:0] rd_q, rd_d;
    logic [2:0] irq_q, irq_d;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    irq_hub #(.EDGE_QUEUE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_super(acc_super), .acc_sel(acc_sel),
        .acc_ctx(acc_ctx), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
        .rd_data(rd_q), .ctx_irq(irq_q));

    irq_hub #(.EDGE_QUEUE(1'b0)) dut_drop_i (
        .clk(clk), .rst_n(rst_n), .src_in(src), .acc_valid(acc_valid),
        .acc_write(acc_write), .acc_super(acc_super), .acc_sel(acc_sel),
        .acc_ctx(acc_ctx), .acc_idx(acc_idx), .acc_wdata(acc_wdata),
        .rd_data(rd_d), .ctx_irq(irq_d));

    // Behavioural model; index k: 0 = queue instance, 1 = drop instance
    int m_st [2][8];
    int m_cnt[2][8];
    int m_own[2][8];
    bit m_prev[2][8];
    int m_rd [2];
    int prio[8];
    bit trig[8];
    bit en[NC][8];
    int thr[NC];
    bit deleg;

    function automatic bit present(int c);
        return (c < NC) && PRES[c];
    endfunction

    function automatic int mwin(int k, int c);
        int best = 0;
        int bp;
        if (!present(c)) return 0;
        bp = thr[c];
        for (int s = 1; s <= NS; s++) begin
            if (m_st[k][s] == 1 && en[c][s] && prio[s] > bp) begin
                best = s;
                bp = prio[s];
            end
        end
        return best;
    endfunction

    function automatic int mread(int k);
        int c = int'(acc_ctx);
        int s = int'(acc_idx);
        bit sv = (s >= 1 && s <= NS);
        case (acc_sel)
            3'd0: return sv ? prio[s] : 0;
            3'd1: return (c < NC && sv) ? int'(en[c][s]) : 0;
            3'd2: return (c < NC) ? thr[c] : 0;
            3'd3: return mwin(k, c);
            3'd4: return sv ? int'(trig[s]) : 0;
            3'd5: return int'(deleg);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin : model
        int cw[2];
        bit ok, cpl, e;
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_rd[k] = 0;
                for (int s = 0; s < 8; s++) begin
                    m_st[k][s] = 0; m_cnt[k][s] = 0; m_own[k][s] = 0; m_prev[k][s] = 0;
                end
            end
            for (int s = 0; s < 8; s++) begin
                prio[s] = 0; trig[s] = 0;
                for (int c = 0; c < NC; c++) en[c][s] = 0;
            end
            for (int c = 0; c < NC; c++) thr[c] = 0;
            deleg = 0;
        end else begin
            ok  = acc_valid && (!acc_super || deleg);
            cpl = ok && acc_write && acc_sel == 3'd3 && present(int'(acc_ctx));
            for (int k = 0; k < 2; k++) begin
                cw[k] = (ok && !acc_write && acc_sel == 3'd3) ? mwin(k, int'(acc_ctx)) : 0;
                if (acc_valid && !acc_write) m_rd[k] = ok ? mread(k) : 0;
            end
            for (int k = 0; k < 2; k++) begin
                for (int s = 1; s <= NS; s++) begin
                    e = trig[s] && src[s-1] && !m_prev[k][s];
                    case (m_st[k][s])
                        0: if (trig[s] ? (e || m_cnt[k][s] > 0) : src[s-1]) begin
                               m_st[k][s] = 1;
                               if (trig[s] && !e && m_cnt[k][s] > 0) m_cnt[k][s]--;
                           end
                        1: if (cw[k] == s) begin
                               m_st[k][s] = 2;
                               m_own[k][s] = int'(acc_ctx);
                               if (k == 0 && e && m_cnt[k][s] < CMAX) m_cnt[k][s]++;
                           end
                        default: begin
                            if (k == 0 && e && m_cnt[k][s] < CMAX) m_cnt[k][s]++;
                            if (cpl && int'(acc_wdata) == s && m_own[k][s] == int'(acc_ctx))
                                m_st[k][s] = 0;
                        end
                    endcase
                    m_prev[k][s] = src[s-1];
                end
            end
            if (ok && acc_write) begin
                case (acc_sel)
                    3'd0: if (acc_idx != 0) prio[acc_idx] = int'(acc_wdata[2:0]);
                    3'd1: if (present(int'(acc_ctx)) && acc_idx != 0) en[acc_ctx][acc_idx] = acc_wdata[0];
                    3'd2: if (present(int'(acc_ctx))) thr[acc_ctx] = int'(acc_wdata[2:0]);
                    3'd4: if (acc_idx != 0) trig[acc_idx] = acc_wdata[0];
                    3'd5: if (!acc_super) deleg = acc_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // Per-cycle comparison against the model (R3 lines, R13 read data)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int k = 0; k < 2; k++) begin
                logic [2:0] irq_a;
                logic [2:0] irq_e;
                int rd_a;
                irq_a = (k == 0) ? irq_q : irq_d;
                rd_a  = (k == 0) ? int'(rd_q) : int'(rd_d);
                for (int c = 0; c < NC; c++) irq_e[c] = (mwin(k, c) != 0);
                checks++;
                if (irq_a != irq_e) begin
                    errors++;
                    $display("FAIL R3 line inst%0d: actual=%b expected=%b", k, irq_a, irq_e);
                end
                checks++;
                if (rd_a != m_rd[k]) begin
                    errors++;
                    $display("FAIL R13 rd inst%0d: actual=%0d expected=%0d", k, rd_a, m_rd[k]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit okc, input string req, input int act, input int exp);
        checks++;
        if (!okc) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic acc(input bit wr, input bit sup, input int sl, input int cx, input int ix, input int wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_super = sup;
        acc_sel = 3'(sl); acc_ctx = 2'(cx); acc_idx = 3'(ix); acc_wdata = 8'(wd);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic rd2(input string req, input bit sup, input int sl, input int cx, input int ix, input int eq, input int ed);
        acc(1'b0, sup, sl, cx, ix, 0);
        chk(int'(rd_q) == eq, {req, " queue"}, int'(rd_q), eq);
        chk(int'(rd_d) == ed, {req, " drop"}, int'(rd_d), ed);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse5();
        @(negedge clk); src[4] = 1'b1;
        @(negedge clk); src[4] = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk(irq_q == 3'b000 && irq_d == 3'b000, "R1 lines after reset", int'(irq_q), 0);
        chk(rd_q == 8'd0, "R1 rd after reset", int'(rd_q), 0);
        rd2("R1 priority reset", 1'b0, 0, 0, 1, 0, 0);

        // Level sources, priorities and enables
        acc(1, 0, 0, 0, 1, 2); acc(1, 0, 0, 0, 2, 5);
        acc(1, 0, 0, 0, 3, 5); acc(1, 0, 0, 0, 4, 1);
        for (int s = 1; s <= 4; s++) acc(1, 0, 1, 0, s, 1);
        acc(1, 0, 1, 2, 2, 1);
        src = 7'b0000111;
        idle(3);
        chk(irq_q[0] && irq_q[2], "R2 lines raised", int'(irq_q), 5);
        rd2("R3 tie lowest id", 0, 3, 0, 0, 2, 2);
        rd2("R2 not enabled ctx2", 0, 3, 2, 0, 0, 0);
        rd2("R3 next equal prio", 0, 3, 0, 0, 3, 3);
        rd2("R3 lower prio", 0, 3, 0, 0, 1, 1);
        rd2("R5 empty claim", 0, 3, 0, 0, 0, 0);
        chk(irq_q[0] == 1'b0, "R5 line low while held", int'(irq_q[0]), 0);
        acc(1, 0, 3, 2, 0, 2);
        rd2("R6 foreign complete ignored", 0, 3, 0, 0, 0, 0);
        acc(1, 0, 3, 0, 0, 2);
        rd2("R7 level re-pend", 0, 3, 2, 0, 2, 2);
        src = '0;
        acc(1, 0, 3, 2, 0, 2); acc(1, 0, 3, 0, 0, 3); acc(1, 0, 3, 0, 0, 1);
        idle(2);

        // Thresholds
        acc(1, 0, 2, 0, 0, 5);
        src[1] = 1'b1;
        idle(3);
        chk(irq_q[0] == 1'b0, "R4 equal to threshold", int'(irq_q[0]), 0);
        chk(irq_q[2] == 1'b1, "R4 above threshold", int'(irq_q[2]), 1);
        acc(1, 0, 0, 0, 2, 0);
        chk(irq_q[2] == 1'b0, "R4 priority zero", int'(irq_q[2]), 0);
        acc(1, 0, 0, 0, 2, 6);
        chk(irq_q[0] == 1'b1, "R4 raised above threshold", int'(irq_q[0]), 1);
        src[1] = 1'b0;
        rd2("R4 claim above threshold", 0, 3, 0, 0, 2, 2);
        acc(1, 0, 3, 0, 0, 2);
        acc(1, 0, 2, 0, 0, 0);
        rd2("R7 level low stays idle", 0, 3, 0, 0, 0, 0);

        // Edge source 5
        acc(1, 0, 4, 0, 5, 1); acc(1, 0, 0, 0, 5, 3); acc(1, 0, 1, 0, 5, 1);
        pulse5();
        chk(irq_q[0] && irq_d[0], "R8 edge sets pending", int'(irq_q[0]), 1);
        pulse5();
        rd2("R8 edge claim", 0, 3, 0, 0, 5, 5);
        rd2("R8 merged edge", 0, 3, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) pulse5();
        for (int r = 0; r < 3; r++) begin
            acc(1, 0, 3, 0, 0, 5);
            idle(1);
            rd2("R9 R10 redelivery", 0, 3, 0, 0, 5, 0);
        end
        acc(1, 0, 3, 0, 0, 5);
        idle(1);
        rd2("R9 saturated backlog drained", 0, 3, 0, 0, 0, 0);

        // Delegation
        acc(1, 1, 0, 0, 1, 7);
        rd2("R11 ignored supervisor write", 0, 0, 0, 1, 2, 2);
        rd2("R11 supervisor read blocked", 1, 0, 0, 1, 0, 0);
        acc(1, 0, 5, 0, 0, 1);
        acc(1, 1, 5, 0, 0, 0);
        rd2("R11 deleg machine only", 0, 5, 0, 0, 1, 1);
        acc(1, 1, 0, 0, 1, 7);
        rd2("R11 supervisor write accepted", 1, 0, 0, 1, 7, 7);

        // Absent context 1
        acc(1, 0, 1, 1, 1, 1);
        src[0] = 1'b1;
        idle(3);
        chk(irq_q[1] == 1'b0, "R12 absent line", int'(irq_q[1]), 0);
        rd2("R12 absent claim", 0, 3, 1, 0, 0, 0);
        rd2("R12 absent enable", 0, 1, 1, 1, 0, 0);
        rd2("R12 out of range claim", 0, 3, 3, 0, 0, 0);

        // Read-back encodings
        rd2("R13 trigger read", 0, 4, 0, 5, 1, 1);
        acc(1, 0, 2, 2, 0, 4);
        rd2("R13 threshold read", 0, 2, 2, 0, 4, 4);
        rd2("R13 id zero read", 0, 0, 0, 0, 0, 0);
        rd2("R3 top priority claim", 0, 3, 0, 0, 1, 1);

        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule